// File: doc/BRIEF.md
# Speech Path Level Control Unit

This unit post-processes linear speech samples for an echo canceller, once per 8 kHz frame. It handles two directions: the receive-in sample that heads for the loudspeaker or line, and the send-out sample that leaves the canceller. A single-cycle `frame_go` pulse marks each frame. On that pulse the unit captures the three samples and the three enable bits, and it updates one smoothed level tracker for receive-in and one for send-in. The processed samples appear two clock edges later, together with a one-cycle `out_valid` pulse.

Three functions can be enabled one by one. The switched attenuator puts 6 dB of loss on exactly one direction, and talker activity picks which one. Gain control compresses receive-in levels above a knee, in half-decibel steps, up to an 8.5 dB cap. Center clipping forces very quiet send-out samples to zero. All level thresholds derive from one parameter, `REF_LVL`, which is the tracker reading that stands for 0 dBm0. With the defaults the knee is `REF_LVL/10` = 1450 (-20 dBm0), the activity threshold is `REF_LVL/100` = 145 and the clip threshold is `REF_LVL/501` = 28 (-54 dBm0).

Top module: `lvc_level_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `rout`, `sout` and `out_valid` are zero until the first processed frame.
- R2: When `frame_go` is high at a clock edge, `out_valid` is high for exactly the cycle that follows the next edge, and `rout`/`sout` then hold their values until the next result.
- R3: Each level tracker updates once per frame, from the samples captured in that frame: L_new = L + floor((|x| - L) / 8). Both the activity and the gain decisions of a frame use the updated levels.
- R4: The attenuator loss is an arithmetic shift right by one. With `en_att` high exactly one direction is attenuated in each frame. With `en_att` low neither direction is.
- R5: A direction is active when its level is above 145. The send-out path is attenuated when receive-in is active and send-in is not. In every other case the receive-in path is attenuated.
- R6: With `en_gc` high and the receive-in level below T1, receive-in passes through gain control unchanged. The knee is T0 = 1450 and Tk = floor(T(k-1)*1085/1024).
- R7: With `en_gc` high the step count k is the number of thresholds T1..T17 that the receive-in level reaches (level >= Tk). The sample becomes floor(x*Gk/32768), where G0 = 32767 and Gk = floor(G(k-1)*967/1024).
- R8: The step count is capped at 17 (8.5 dB), so any level above T17, including full-scale input, uses G17.
- R9: With `en_clip` high, a send-out sample whose magnitude after attenuation is below 28 is replaced by zero. A magnitude of 28 or more passes.
- R10: The enable bits are sampled only on `frame_go` (and continuously during reset). A change between frame starts does not affect the frame in flight.
- R11: With all three enables low, `rout` equals `rin_in` and `sout` equals `sout_in` of the frame, including -32768.
- R12: On receive-in, gain control is applied before attenuation, and neither ever increases the sample magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_go | input | 1 | One-cycle pulse that starts a frame and captures samples and enables |
| en_att | input | 1 | Switched attenuator enable |
| en_gc | input | 1 | Receive-in gain control enable |
| en_clip | input | 1 | Send-out center clip enable |
| rin_in | input | W | Signed receive-in sample |
| sin_in | input | W | Signed send-in sample, used only for activity |
| sout_in | input | W | Signed send-out sample from the canceller |
| rout | output | W | Processed receive-in sample |
| sout | output | W | Processed send-out sample |
| out_valid | output | 1 | Pulses when rout/sout carry a new frame result |

## Verification
The bench drives long runs at constant amplitude so that the receive-in tracker settles below the knee, between T1 and T17, and above the cap. A design with an off-by-one step count or a wrongly built gain table would then give the wrong compressed value, and one without the cap would overflow its table. Clip is tested at magnitudes 27 and 28 of both signs, and also on a sample that falls below the threshold only after the 6 dB shift. A clipper placed before the attenuator, or one that compares with less-or-equal, shows up there. Activity runs switch between receive-in only, both talking and silence, which catches a steering rule that inverts a case or attenuates both paths. Enable bits are flipped between a frame start and its result, so a design that reads the enables live produces a different output.

// File: rtl/lvc_pkg.sv
// Shared types and constant helpers for the speech path level control unit.
// Assumes step ratios are expressed as num/1024 in fixed point.
package lvc_pkg;

    typedef struct packed {
        logic att;
        logic gc;
        logic clip;
    } lvc_en_t;

    localparam int unsigned STEP_SH     = 10;
    localparam int unsigned UP_NUM      = 1085;   // +0.5 dB per step
    localparam int unsigned DN_NUM      = 967;    // -0.5 dB per step
    localparam int unsigned GAIN_ONE    = 32767;  // unity in Q15
    localparam int unsigned GAIN_FRAC   = 15;

    // Apply k successive num/1024 scalings to base (constant evaluation only).
    function automatic int unsigned scale_steps(int unsigned base, int unsigned num, int unsigned k);
        int unsigned v;
        v = base;
        for (int unsigned i = 0; i < k; i++) begin
            v = (v * num) >> STEP_SH;
        end
        return v;
    endfunction

endpackage

// File: rtl/lvc_level_track.sv
// First-order smoothed magnitude tracker. Once per update pulse:
// lvl <= lvl + floor((|smp| - lvl) >> SHIFT). Assumes SHIFT >= 1.
module lvc_level_track #(
    parameter int W     = 16,
    parameter int SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic signed [W-1:0] smp,
    output logic [W:0]          lvl
);
    localparam int LW = W + 1;

    logic signed [LW-1:0] ext;
    logic [LW-1:0]        mag;
    logic signed [LW+1:0] diff;
    logic signed [LW+1:0] nxt;

    // Magnitude of the incoming sample and the smoothed next level.
    always_comb begin
        ext  = {smp[W-1], smp};
        mag  = smp[W-1] ? LW'(-ext) : LW'(ext);
        diff = $signed({2'b00, mag}) - $signed({2'b00, lvl});
        nxt  = $signed({2'b00, lvl}) + (diff >>> SHIFT);
    end

    // Level register, advanced once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0;
        end else if (upd) begin
            lvl <= nxt[LW-1:0];
        end
    end
endmodule

// File: rtl/lvc_gain_stage.sv
// Receive-in compressor: counts how many half-dB thresholds above the knee the
// level reaches (capped at STEPS) and scales the sample by the matching Q15 gain.
// Assumes KNEE*1085^STEPS/1024^STEPS fits in 32 bits.
module lvc_gain_stage #(
    parameter int W     = 16,
    parameter int KNEE  = 1450,
    parameter int STEPS = 17
) (
    input  logic                en,
    input  logic [W:0]          lvl,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    import lvc_pkg::*;

    localparam int IW = $clog2(STEPS + 1);
    localparam int PW = W + 17;

    logic [STEPS-1:0]     hit;
    logic [15:0]          gtab [STEPS+1];
    logic [IW-1:0]        idx;
    logic [15:0]          gsel;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    // Threshold comparators and gain table entries, one per step.
    for (genvar k = 1; k <= STEPS; k++) begin : g_step
        localparam int unsigned TK = scale_steps(KNEE, UP_NUM, k);
        assign hit[k-1] = (32'(lvl) >= TK);
        assign gtab[k]  = 16'(scale_steps(GAIN_ONE, DN_NUM, k));
    end
    assign gtab[0] = 16'(GAIN_ONE);

    // Step count: thresholds rise monotonically, so the count of hits is the index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < STEPS; k++) begin
            idx = idx + IW'(hit[k]);
        end
    end

    // Gain selection for the current step count.
    always_comb begin
        gsel = gtab[0];
        for (int k = 1; k <= STEPS; k++) begin
            if (idx == IW'(k)) gsel = gtab[k];
        end
    end

    // Scale and floor; bypass when disabled or below the first step.
    always_comb begin
        prod    = PW'(x) * PW'($signed({1'b0, gsel}));
        shifted = prod >>> GAIN_FRAC;
        y       = (en && idx != '0) ? shifted[W-1:0] : x;
    end
endmodule

// File: rtl/lvc_path_steer.sv
// Chooses which direction takes the switched loss from talker activity.
// Exactly one of att_rin/att_sout is high when en is high; none otherwise.
module lvc_path_steer #(
    parameter int LW      = 17,
    parameter int ACT_THR = 145
) (
    input  logic          en,
    input  logic [LW-1:0] rin_lvl,
    input  logic [LW-1:0] sin_lvl,
    output logic          att_rin,
    output logic          att_sout
);
    logic rin_act;
    logic sin_act;
    logic pick_sout;

    // Activity flags and the steering rule.
    always_comb begin
        rin_act   = rin_lvl > LW'(ACT_THR);
        sin_act   = sin_lvl > LW'(ACT_THR);
        pick_sout = rin_act && !sin_act;
        att_sout  = en && pick_sout;
        att_rin   = en && !pick_sout;
    end
endmodule

// File: rtl/lvc_level_ctrl.sv
// Speech path level control unit top. Stage one (frame_go) captures samples and
// enables and advances the level trackers; stage two computes and registers
// rout/sout and pulses out_valid. Assumes frame_go is a single-cycle pulse.
module lvc_level_ctrl #(
    parameter int W         = 16,
    parameter int REF_LVL   = 14500,
    parameter int KNEE_DIV  = 10,
    parameter int ACT_DIV   = 100,
    parameter int CLIP_DIV  = 501,
    parameter int TRK_SHIFT = 3,
    parameter int GC_STEPS  = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_go,
    input  logic                en_att,
    input  logic                en_gc,
    input  logic                en_clip,
    input  logic signed [W-1:0] rin_in,
    input  logic signed [W-1:0] sin_in,
    input  logic signed [W-1:0] sout_in,
    output logic signed [W-1:0] rout,
    output logic signed [W-1:0] sout,
    output logic                out_valid
);
    import lvc_pkg::*;

    localparam int LW       = W + 1;
    localparam int KNEE     = REF_LVL / KNEE_DIV;
    localparam int ACT_THR  = REF_LVL / ACT_DIV;
    localparam int CLIP_THR = REF_LVL / CLIP_DIV;

    lvc_en_t              en_q;
    lvc_en_t              en_o;
    logic signed [W-1:0]  cap_rin;
    logic signed [W-1:0]  cap_sout;
    logic                 pend;
    logic signed [W-1:0]  trk_in  [2];
    logic [LW-1:0]        trk_lvl [2];
    logic signed [W-1:0]  g_rin;
    logic                 att_rin;
    logic                 att_sout;
    logic                 att_rin_o;
    logic                 att_sout_o;
    logic signed [W-1:0]  r_pre;
    logic signed [W-1:0]  s_pre;
    logic signed [LW-1:0] s_ext;
    logic [LW-1:0]        s_mag;
    logic signed [W-1:0]  s_post;

    // Stage one: capture frame samples and enables (enables follow inputs in reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_rin  <= '0;
            cap_sout <= '0;
            en_q     <= '{att: en_att, gc: en_gc, clip: en_clip};
            pend     <= 1'b0;
        end else begin
            if (frame_go) begin
                cap_rin  <= rin_in;
                cap_sout <= sout_in;
                en_q     <= '{att: en_att, gc: en_gc, clip: en_clip};
            end
            pend <= frame_go;
        end
    end

    // One tracker per observed direction: index 0 receive-in, index 1 send-in.
    assign trk_in[0] = rin_in;
    assign trk_in[1] = sin_in;
    for (genvar p = 0; p < 2; p++) begin : g_trk
        lvc_level_track #(.W(W), .SHIFT(TRK_SHIFT)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (frame_go),
            .smp   (trk_in[p]),
            .lvl   (trk_lvl[p])
        );
    end

    lvc_gain_stage #(.W(W), .KNEE(KNEE), .STEPS(GC_STEPS)) u_gain (
        .en  (en_q.gc),
        .lvl (trk_lvl[0]),
        .x   (cap_rin),
        .y   (g_rin)
    );

    lvc_path_steer #(.LW(LW), .ACT_THR(ACT_THR)) u_steer (
        .en       (en_q.att),
        .rin_lvl  (trk_lvl[0]),
        .sin_lvl  (trk_lvl[1]),
        .att_rin  (att_rin),
        .att_sout (att_sout)
    );

    // Apply the switched loss, then clip the quiet send-out samples.
    always_comb begin
        r_pre  = att_rin  ? (g_rin >>> 1)    : g_rin;
        s_pre  = att_sout ? (cap_sout >>> 1) : cap_sout;
        s_ext  = {s_pre[W-1], s_pre};
        s_mag  = s_pre[W-1] ? LW'(-s_ext) : LW'(s_ext);
        s_post = (en_q.clip && s_mag < LW'(CLIP_THR)) ? '0 : s_pre;
    end

    // Stage two: register the frame result and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rout       <= '0;
            sout       <= '0;
            out_valid  <= 1'b0;
            en_o       <= '0;
            att_rin_o  <= 1'b0;
            att_sout_o <= 1'b0;
        end else begin
            out_valid <= pend;
            if (pend) begin
                rout       <= r_pre;
                sout       <= s_post;
                en_o       <= en_q;
                att_rin_o  <= att_rin;
                att_sout_o <= att_sout;
            end
        end
    end
endmodule

// File: rtl/lvc_level_ctrl_chk.sv
// Property checker for lvc_level_ctrl, attached by bind below.
// Assumes it sees the frame capture registers and the per-result snapshots.
module lvc_level_ctrl_chk #(
    parameter int W        = 16,
    parameter int CLIP_THR = 28
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_go,
    input logic                out_valid,
    input logic signed [W-1:0] rout,
    input logic signed [W-1:0] sout,
    input logic signed [W-1:0] cap_rin,
    input logic signed [W-1:0] cap_sout,
    input lvc_pkg::lvc_en_t    en_q,
    input lvc_pkg::lvc_en_t    en_o,
    input logic                att_rin_o,
    input logic                att_sout_o
);
    function automatic logic [W:0] mag(input logic signed [W-1:0] v);
        logic signed [W:0] e;
        e = {v[W-1], v};
        return v[W-1] ? (W+1)'(-e) : (W+1)'(e);
    endfunction

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> ##1 out_valid); // R2

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({att_rin_o, att_sout_o}) == (en_o.att ? 1 : 0))); // R4

    AST_CLIP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && en_o.clip && sout != '0) |-> (mag(sout) >= (W+1)'(CLIP_THR))); // R9

    AST_NO_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mag(rout) <= mag($past(cap_rin)))); // R12

    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && en_o == '0) |-> (rout == $past(cap_rin) && sout == $past(cap_sout))); // R11

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |=> $stable(en_q)); // R10
endmodule

bind lvc_level_ctrl lvc_level_ctrl_chk #(.W(W), .CLIP_THR(CLIP_THR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_go   (frame_go),
    .out_valid  (out_valid),
    .rout       (rout),
    .sout       (sout),
    .cap_rin    (cap_rin),
    .cap_sout   (cap_sout),
    .en_q       (en_q),
    .en_o       (en_o),
    .att_rin_o  (att_rin_o),
    .att_sout_o (att_sout_o)
);

// File: tb/sim_lvc_level_ctrl.sv
// Self-checking bench with a behavioural per-frame reference model.
module sim_lvc_level_ctrl;
    localparam int W     = 16;
    localparam int KNEE  = 14500 / 10;
    localparam int ACT   = 14500 / 100;
    localparam int CLIPT = 14500 / 501;
    localparam int NST   = 17;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                frame_go = 1'b0;
    logic                en_att = 1'b0, en_gc = 1'b0, en_clip = 1'b0;
    logic signed [W-1:0] rin_in = '0, sin_in = '0, sout_in = '0;
    logic signed [W-1:0] rout, sout;
    logic                out_valid;

    int n_chk = 0;
    int n_fail = 0;
    int thr [NST+1];
    int gn  [NST+1];
    int rl = 0, sl = 0;
    int exp_r = 0, exp_s = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvc_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
        .en_att(en_att), .en_gc(en_gc), .en_clip(en_clip),
        .rin_in(rin_in), .sin_in(sin_in), .sout_in(sout_in),
        .rout(rout), .sout(sout), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int mag(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference model for one frame (R3, R4, R5, R6, R7, R8, R9, R12).
    task automatic model_step(input int r, input int s, input int o);
        int k, g, so;
        bit sa, ra;
        rl = rl + ((mag(r) - rl) >>> 3);
        sl = sl + ((mag(s) - sl) >>> 3);
        k = 0;
        for (int i = 1; i <= NST; i++) if (rl >= thr[i]) k++;
        g = r;
        if (en_gc && k > 0) g = (r * gn[k]) >>> 15;
        sa = en_att && (rl > ACT) && !(sl > ACT);
        ra = en_att && !sa;
        exp_r = ra ? (g >>> 1) : g;
        so = sa ? (o >>> 1) : o;
        if (en_clip && mag(so) < CLIPT) so = 0;
        exp_s = so;
    endtask

    // Drive one frame at a negedge and check each following negedge.
    task automatic frame(input int r, input int s, input int o, input bit flip, input string tag);
        rin_in = W'(r); sin_in = W'(s); sout_in = W'(o); frame_go = 1'b1;
        model_step(r, s, o);
        @(negedge clk);
        frame_go = 1'b0;
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
        if (flip) begin
            en_att = !en_att; en_gc = !en_gc; en_clip = !en_clip;
        end
        @(negedge clk);
        chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
        chk(int'(rout) == exp_r, {tag, " rout"}, int'(rout), exp_r);
        chk(int'(sout) == exp_s, {tag, " sout"}, int'(sout), exp_s);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
        chk(int'(rout) == exp_r, "R2 hold", int'(rout), exp_r);
    endtask

    task automatic run(input int n, input int ra, input int sa, input int o, input string tag);
        for (int i = 0; i < n; i++) begin
            frame((i % 2) ? ra : -ra, (i % 2) ? -sa : sa, (i % 3 == 0) ? -o : o, 1'b0, tag);
        end
    endtask

    initial begin
        thr[0] = KNEE;
        gn[0]  = 32767;
        for (int k = 1; k <= NST; k++) begin
            thr[k] = (thr[k-1] * 1085) / 1024;
            gn[k]  = (gn[k-1] * 967) / 1024;
        end
        en_att = 1'b1; en_gc = 1'b1; en_clip = 1'b1;
        rin_in = 16'sd1234; sout_in = -16'sd999;
        repeat (3) @(negedge clk);
        chk(rout == '0, "R1", int'(rout), 0);
        chk(sout == '0, "R1", int'(sout), 0);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && rout == '0, "R1", int'(rout), 0);

        // R11: all functions off, plain pass-through including full scale.
        en_att = 1'b0; en_gc = 1'b0; en_clip = 1'b0;
        frame(-32768, 0, -32768, 1'b0, "R11");
        frame(32767, 100, 5, 1'b0, "R11");
        frame(-7, 3, 27, 1'b0, "R11");
        frame(1, 0, -1, 1'b0, "R11");

        // R4/R5: receive-in only talking -> send-out attenuated.
        en_att = 1'b1;
        run(20, 3000, 0, 501, "R5 rin-only");
        // R4/R5: both talking -> receive-in attenuated.
        run(20, 3000, 2000, 501, "R5 double");
        // R3/R5: both silent after decay -> receive-in attenuated.
        run(40, 0, 0, -333, "R3 R5 silent");

        // R6: gain control below the knee leaves samples alone.
        en_att = 1'b0; en_gc = 1'b1;
        run(40, 1000, 0, 0, "R6");
        // R7: level between knee and cap -> partial compression.
        run(40, 2500, 0, 0, "R7");
        run(30, 1800, 0, 0, "R7");
        // R8: loud input -> capped loss, full scale too.
        run(40, 9000, 0, 0, "R8");
        frame(-32768, 0, 0, 1'b0, "R8");
        frame(32767, 0, 0, 1'b0, "R8");

        // R9: clip boundary on the raw send-out sample.
        en_gc = 1'b0; en_clip = 1'b1;
        frame(0, 0, 27, 1'b0, "R9");
        frame(0, 0, -27, 1'b0, "R9");
        frame(0, 0, 28, 1'b0, "R9");
        frame(0, 0, -28, 1'b0, "R9");
        frame(0, 0, 0, 1'b0, "R9");
        // R9: clip applies after attenuation (55 -> 27 clipped, 56 -> 28 kept).
        en_att = 1'b1;
        run(10, 4000, 0, 55, "R9 post-att");
        run(10, 4000, 0, 56, "R9 post-att");

        // R12: gain then loss together on a loud receive-in with send-in active.
        en_gc = 1'b1; en_clip = 1'b0;
        run(40, 12000, 3000, 700, "R12");

        // R10: enables toggled between capture and result have no effect.
        for (int i = 0; i < 12; i++) begin
            frame((i % 2) ? 5000 : -5000, 0, (i % 2) ? 40 : -20, 1'b1, "R10");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule